// File: doc/BRIEF.md
# Parallel I/O Port with Software Tristate Release

This block is a 24-bit host-programmed parallel port. The pins form two full ports, A and B, and a third port, C, which is split into a low nibble and a high nibble. Each of the four groups is set as input or output by one host-written control byte. Only plain input/output operation is offered: there is no handshake mode and no single-bit set or reset command. Output groups drive the value held in their latch. When the host reads a group, an input group returns the pin state and an output group returns its latch.

A strap input can select a tristate discipline. With the strap set, every accepted control byte leaves all 24 pins undriven. The host can then load the output latches while nothing is driven. A write to a separate release register then lets every output group drive at the same moment. The same register can also park the pins undriven again without disturbing the directions. This lets software change directions without glitches. The pads are modelled as separate output-enable, output-value and input-value vectors. Undriven pins are pulled up externally.

Top module: `pio24_tristate`

## Requirements
- R1: After reset, all 24 output enables are 0, every output latch is 0, and a read of the mode address (3) returns 0x9B.
- R2: A write to the mode address (3) with bit 7 = 1 sets the group directions, where 1 means input and 0 means output: bit 4 sets port A, bit 1 sets port B, bit 0 sets the port C low nibble and bit 3 sets the port C high nibble. With the strap clear, the output enables follow in the next cycle. Reading address 3 returns bit 7 set, the four direction bits in those positions, and 0 in bits 6, 5 and 2.
- R3: A write to the mode address with bit 7 = 0 is ignored. The directions, the latches and the pins stay unchanged.
- R4: Every accepted mode write clears all output latches to 0, including those of groups that were already outputs.
- R5: A data write (address 0 = A, 1 = B, 2 = C, where C bits 3:0 form the low nibble and bits 7:4 the high nibble) updates only the groups configured as outputs. The latch of an input group keeps its value.
- R6: A read of a port address returns the pin values for input groups and the latch values for output groups. Output latches appear on pad_out: A on bits 7:0, B on bits 15:8, the C low nibble on bits 19:16 and the C high nibble on bits 23:20.
- R7: With the strap set, every accepted mode write makes all output enables 0 in the next cycle. Output latches can still be written while the pins are undriven.
- R8: With the strap set, a write to the release address (4) with bit 7 = 0 enables all output groups together, each driving its latch. A write with bit 7 = 1 disables every output enable and leaves the directions unchanged.
- R9: With the strap clear, writes to the release address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tri_strap | input | 1 | 1 selects the tristate-on-mode-write discipline |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Write address: 0 A, 1 B, 2 C, 3 mode, 4 release |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 3 | Read address; combinational read |
| rd_data | output | 8 | Read data |
| pad_in | input | 24 | Pin values seen at the pads |
| pad_oe | output | 24 | Per-pin output enable |
| pad_out | output | 24 | Per-pin output value (latch contents) |

## Verification
On every cycle the checker confirms several properties. An accepted mode write empties every latch. Under the strap it also disables all drivers one cycle later. A rejected mode byte leaves both pad vectors untouched. A release write has no effect without the strap. A park write disables all drivers. The output enable stays uniform across each group. The bench scenarios are needed for the rest: the decode of each direction bit, the per-nibble masking of port C writes, read-back of pins against latches including pulled-up undriven pins, latch loading while the pins are parked, and the simultaneous release.

// File: rtl/pio24_pkg.sv
package pio24_pkg;

   localparam int unsigned NUM_GRP  = 4;
   localparam int unsigned ADR_PA   = 0;
   localparam int unsigned ADR_PB   = 1;
   localparam int unsigned ADR_PC   = 2;
   localparam int unsigned ADR_MODE = 3;
   localparam int unsigned ADR_REL  = 4;
   localparam int unsigned FLAG_BIT = 7;

   typedef enum logic [1:0] {GRP_A = 2'd0, GRP_B = 2'd1, GRP_CLO = 2'd2, GRP_CHI = 2'd3} grp_e;

   function automatic int unsigned grp_width(int unsigned g, int unsigned pw);
      return (g < 2) ? pw : pw / 2;
   endfunction

   function automatic int unsigned grp_pad_lsb(int unsigned g, int unsigned pw);
      case (g)
         0:       return 0;
         1:       return pw;
         2:       return 2 * pw;
         default: return 2 * pw + pw / 2;
      endcase
   endfunction

   function automatic int unsigned grp_dat_lsb(int unsigned g, int unsigned pw);
      return (g == 3) ? pw / 2 : 0;
   endfunction

   // position of a group's direction bit in the control byte
   function automatic int unsigned grp_dir_bit(int unsigned g);
      case (g)
         0:       return 4;
         1:       return 1;
         2:       return 0;
         default: return 3;
      endcase
   endfunction

   function automatic int unsigned grp_port(int unsigned g);
      return (g < 2) ? g : 2;
   endfunction

endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
   import pio24_pkg::*;
#(
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned PORT_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 strap,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic                 cmd_flag,
   input  logic [NUM_GRP-1:0]   cmd_dir,
   output logic [NUM_GRP-1:0]   dir_in,
   output logic                 float_all,
   output logic                 mode_set,
   output logic [PORT_W-1:0]    ctrl_byte
);

   logic [NUM_GRP-1:0] dir_q;
   logic               float_q;
   logic               rel_hit;

   assign mode_set = wr_en && (wr_addr == ADDR_W'(ADR_MODE)) && cmd_flag;
   assign rel_hit  = wr_en && (wr_addr == ADDR_W'(ADR_REL));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q   <= '1;
         float_q <= 1'b0;
      end else if (mode_set) begin
         dir_q   <= cmd_dir;
         float_q <= strap;
      end else if (rel_hit && strap) begin
         float_q <= cmd_flag;
      end
   end

   assign dir_in    = dir_q;
   assign float_all = strap & float_q;

   always_comb begin
      ctrl_byte           = '0;
      ctrl_byte[FLAG_BIT] = 1'b1;
      for (int g = 0; g < NUM_GRP; g++) begin
         ctrl_byte[grp_dir_bit(g)] = dir_q[g];
      end
   end

endmodule

// File: rtl/pio_grp.sv
module pio_grp #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         ld,
   input  logic         dir_in,
   input  logic         float_all,
   input  logic [W-1:0] d,
   input  logic [W-1:0] pin,
   output logic [W-1:0] oe,
   output logic [W-1:0] q,
   output logic [W-1:0] rd
);

   logic [W-1:0] latch_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         latch_q <= '0;
      end else if (ld && !dir_in) begin
         latch_q <= d;
      end
   end

   assign q  = latch_q;
   assign oe = {W{~dir_in & ~float_all}};
   assign rd = dir_in ? pin : latch_q;

endmodule

// File: rtl/pio_rdmux.sv
module pio_rdmux
   import pio24_pkg::*;
#(
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned PORT_W = 8
) (
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [PORT_W-1:0] val_a,
   input  logic [PORT_W-1:0] val_b,
   input  logic [PORT_W-1:0] val_c,
   input  logic [PORT_W-1:0] val_mode,
   output logic [PORT_W-1:0] rd_data
);

   always_comb begin
      if (rd_addr == ADDR_W'(ADR_PA))        rd_data = val_a;
      else if (rd_addr == ADDR_W'(ADR_PB))   rd_data = val_b;
      else if (rd_addr == ADDR_W'(ADR_PC))   rd_data = val_c;
      else if (rd_addr == ADDR_W'(ADR_MODE)) rd_data = val_mode;
      else                                   rd_data = '0;
   end

endmodule

// File: rtl/pio24_tristate.sv
module pio24_tristate
   import pio24_pkg::*;
#(
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned PORT_W = 8,
   localparam int unsigned PAD_W = 3 * PORT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tri_strap,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [PORT_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [PORT_W-1:0] rd_data,
   input  logic [PAD_W-1:0]  pad_in,
   output logic [PAD_W-1:0]  pad_oe,
   output logic [PAD_W-1:0]  pad_out
);

   if (PORT_W < 8 || (PORT_W % 2) != 0) begin : g_bad_port_w
      $error("pio24_tristate: PORT_W must be even and at least 8");
   end
   if (ADDR_W < 3) begin : g_bad_addr_w
      $error("pio24_tristate: ADDR_W must be at least 3");
   end

   logic [NUM_GRP-1:0] dir_in;
   logic               float_all;
   logic               mode_set;
   logic [PORT_W-1:0]  ctrl_byte;
   logic [PAD_W-1:0]   rd_bus;

   pio_ctrl #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap     (tri_strap),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .cmd_flag  (wr_data[FLAG_BIT]),
      .cmd_dir   ({wr_data[grp_dir_bit(3)], wr_data[grp_dir_bit(2)],
                   wr_data[grp_dir_bit(1)], wr_data[grp_dir_bit(0)]}),
      .dir_in    (dir_in),
      .float_all (float_all),
      .mode_set  (mode_set),
      .ctrl_byte (ctrl_byte)
   );

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      localparam int unsigned GW = grp_width(g, PORT_W);
      localparam int unsigned PL = grp_pad_lsb(g, PORT_W);
      localparam int unsigned DL = grp_dat_lsb(g, PORT_W);
      localparam int unsigned PR = grp_port(g);

      logic ld;
      assign ld = wr_en && (wr_addr == ADDR_W'(PR));

      pio_grp #(.W(GW)) u_grp (
         .clk       (clk),
         .rst_n     (rst_n),
         .clr       (mode_set),
         .ld        (ld),
         .dir_in    (dir_in[g]),
         .float_all (float_all),
         .d         (wr_data[DL +: GW]),
         .pin       (pad_in[PL +: GW]),
         .oe        (pad_oe[PL +: GW]),
         .q         (pad_out[PL +: GW]),
         .rd        (rd_bus[PL +: GW])
      );
   end

   pio_rdmux #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_rdmux (
      .rd_addr  (rd_addr),
      .val_a    (rd_bus[PORT_W-1:0]),
      .val_b    (rd_bus[2*PORT_W-1:PORT_W]),
      .val_c    (rd_bus[3*PORT_W-1:2*PORT_W]),
      .val_mode (ctrl_byte),
      .rd_data  (rd_data)
   );

endmodule

// File: rtl/pio24_tristate_chk.sv
module pio24_tristate_chk
   import pio24_pkg::*;
#(
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned PORT_W = 8,
   localparam int unsigned PAD_W = 3 * PORT_W,
   localparam int unsigned HW    = PORT_W / 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tri_strap,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              wr_flag,
   input logic [PAD_W-1:0]  pad_oe,
   input logic [PAD_W-1:0]  pad_out
);

   logic mode_wr, rel_wr;
   assign mode_wr = wr_en && (wr_addr == ADDR_W'(ADR_MODE));
   assign rel_wr  = wr_en && (wr_addr == ADDR_W'(ADR_REL));

   // R4: an accepted mode write leaves every latch cleared
   a_r4_mode_clears: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr && wr_flag |=> pad_out == '0);

   // R7: under the strap an accepted mode write parks all pins
   a_r7_mode_floats: assert property (@(posedge clk) disable iff (!rst_n)
      tri_strap && mode_wr && wr_flag |=> pad_oe == '0);

   // R3: a mode byte without the flag changes nothing on the pads
   a_r3_flag_low_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr && !wr_flag |=> $stable(pad_oe) && $stable(pad_out));

   // R9: release writes are inert without the strap
   a_r9_release_inert: assert property (@(posedge clk) disable iff (!rst_n)
      !tri_strap && rel_wr |=> $stable(pad_oe));

   // R8: a park write disables every driver
   a_r8_park: assert property (@(posedge clk) disable iff (!rst_n)
      tri_strap && rel_wr && wr_flag |=> pad_oe == '0);

   // R2: enables are uniform within each group
   a_r2_group_uniform: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(pad_oe[PORT_W-1:0]) % PORT_W == 0) &&
      ($countones(pad_oe[2*PORT_W-1:PORT_W]) % PORT_W == 0) &&
      ($countones(pad_oe[2*PORT_W+HW-1:2*PORT_W]) % HW == 0) &&
      ($countones(pad_oe[PAD_W-1:2*PORT_W+HW]) % HW == 0));

endmodule

bind pio24_tristate pio24_tristate_chk #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tri_strap (tri_strap),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_flag   (wr_data[pio24_pkg::FLAG_BIT]),
   .pad_oe    (pad_oe),
   .pad_out   (pad_out)
);

// File: tb/pio24_tristate_tb_top.sv
`timescale 1ns/1ps
module pio24_tristate_tb_top;

   localparam int KIND_RD  = 0;
   localparam int KIND_OE  = 1;
   localparam int KIND_OUT = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tri_strap = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [7:0]  rd_data;
   logic [23:0] pad_in, pad_oe, pad_out;
   logic [23:0] ext_en = '0;
   logic [23:0] ext_val = '0;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [23:0] exp_q[$];
   int          kind_q[$];
   string       tag_q[$];
   event        mon_ev;

   always #10 clk = ~clk;

   // pads: driven pins loop back, undriven pins take the external value or the pull-up
   assign pad_in = (pad_oe & pad_out) | (~pad_oe & ((ext_en & ext_val) | ~ext_en));

   pio24_tristate dut_i (
      .clk(clk), .rst_n(rst_n), .tri_strap(tri_strap),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
   );

   // monitor: pops expectations and compares against the outputs
   initial begin
      forever begin
         @(mon_ev);
         #1;
         while (exp_q.size() > 0) begin
            logic [23:0] e, a;
            int k;
            string t;
            e = exp_q.pop_front();
            k = kind_q.pop_front();
            t = tag_q.pop_front();
            a = (k == KIND_RD) ? {16'h0, rd_data} : (k == KIND_OE) ? pad_oe : pad_out;
            n_tests++;
            if (a !== e) begin
               n_fail++;
               $display("FAIL %s: actual 0x%06h expected 0x%06h", t, a, e);
            end
         end
      end
   end

   task automatic expect_item(input int kind, input logic [2:0] a, input logic [23:0] e,
                              input string tag);
      @(negedge clk);
      rd_addr = a;
      exp_q.push_back(e);
      kind_q.push_back(kind);
      tag_q.push_back(tag);
      -> mon_ev;
      #2;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_reset(input logic strap);
      @(negedge clk);
      tri_strap = strap;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      do_reset(1'b0);
      // R1 reset state
      expect_item(KIND_OE, 0, 24'h000000, "R1 oe after reset");
      expect_item(KIND_OUT, 0, 24'h000000, "R1 latches after reset");
      expect_item(KIND_RD, 3, 24'h00009B, "R1 mode readback");
      expect_item(KIND_RD, 0, 24'h0000FF, "R6 undriven input reads pull-up");

      wr(3, 8'h80);
      expect_item(KIND_OE, 0, 24'hFFFFFF, "R2 all outputs");
      expect_item(KIND_RD, 3, 24'h000080, "R2 mode readback");
      wr(0, 8'h5A); wr(1, 8'hC3); wr(2, 8'h7E);
      expect_item(KIND_RD, 0, 24'h00005A, "R6 read A latch");
      expect_item(KIND_RD, 1, 24'h0000C3, "R6 read B latch");
      expect_item(KIND_RD, 2, 24'h00007E, "R6 read C latch");
      expect_item(KIND_OUT, 0, 24'h7EC35A, "R6 pad_out layout");

      wr(3, 8'h00);
      expect_item(KIND_RD, 3, 24'h000080, "R3 flag-low mode ignored");
      expect_item(KIND_OUT, 0, 24'h7EC35A, "R3 latches kept");

      wr(4, 8'h80);
      expect_item(KIND_OE, 0, 24'hFFFFFF, "R9 release inert without strap");

      wr(3, 8'h88);
      expect_item(KIND_OUT, 0, 24'h000000, "R4 mode write clears latches");
      expect_item(KIND_OE, 0, 24'h0FFFFF, "R2 C high nibble input");
      expect_item(KIND_RD, 3, 24'h000088, "R2 mode readback 0x88");
      ext_en = 24'hF00000; ext_val = 24'h300000;
      wr(2, 8'hA5);
      expect_item(KIND_RD, 2, 24'h000035, "R5 C split read");
      expect_item(KIND_OUT, 0, 24'h050000, "R5 only low nibble latched");

      ext_en = 24'h00FF00; ext_val = 24'h006D00;
      wr(3, 8'h92);
      expect_item(KIND_OE, 0, 24'hFF0000, "R2 A and B inputs");
      wr(0, 8'h11);
      expect_item(KIND_OUT, 0, 24'h000000, "R5 write to input A ignored");
      expect_item(KIND_RD, 0, 24'h0000FF, "R6 A reads pins");
      expect_item(KIND_RD, 1, 24'h00006D, "R6 B reads external");

      // tristate strap phase
      ext_en = '0;
      do_reset(1'b1);
      expect_item(KIND_OE, 0, 24'h000000, "R1 oe after reset strap");
      wr(3, 8'h80);
      expect_item(KIND_OE, 0, 24'h000000, "R7 mode write floats");
      wr(0, 8'h3C);
      expect_item(KIND_OUT, 0, 24'h00003C, "R7 latch written while floating");
      expect_item(KIND_OE, 0, 24'h000000, "R7 still floating");
      expect_item(KIND_RD, 0, 24'h00003C, "R6 floating output reads latch");
      wr(4, 8'h00);
      expect_item(KIND_OE, 0, 24'hFFFFFF, "R8 release drives all");
      expect_item(KIND_OUT, 0, 24'h00003C, "R8 preloaded value driven");
      wr(4, 8'h80);
      expect_item(KIND_OE, 0, 24'h000000, "R8 park floats all");
      expect_item(KIND_RD, 3, 24'h000080, "R8 park keeps mode");
      wr(4, 8'h00);
      expect_item(KIND_OE, 0, 24'hFFFFFF, "R8 re-release");
      wr(3, 8'h83);
      expect_item(KIND_OE, 0, 24'h000000, "R7 second mode write floats");
      wr(4, 8'h00);
      expect_item(KIND_OE, 0, 24'hF000FF, "R8 release with mixed directions");

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule